// File: doc/BRIEF.md
# USB OUT Endpoint Receive Buffer

This block holds the receive side of one USB device OUT endpoint. An upstream packet engine, which has already done the line decoding and the CRC check, gives the block a start strobe with the toggle bit of the data PID, a stream of byte strobes, and an end strobe with a CRC-good flag. The block stores up to 64 bytes. On a clean end of packet it answers ACK or NAK on a one-cycle handshake output. A packet that fails is dropped, and the block sends no handshake for it.

When a fresh packet with the expected data toggle arrives and the endpoint is armed, the block latches the byte count and raises a data-available flag. The local controller reads the count and pulls the bytes out one at a time through a pop strobe and a read-data port. It then writes 1 to the clear input to arm the endpoint again. While the flag is up, incoming packets are refused with NAK and the stored bytes stay as they are.

Top module: `out_ep_rx_buffer`

## Requirements
- R1: After reset the data-available flag is 0, the byte count is 0, read data is 0, and the expected data toggle is DATA0 (toggle bit 0).
- R2: A packet that ends with CRC good, holds no more than 64 bytes, carries the expected toggle and finds the flag clear is answered by `hsAck` high in the cycle after `pktEnd`. In that same cycle `dataAvail` goes to 1, `byteCount` takes the number of bytes received, and the expected toggle inverts.
- R3: While `dataAvail` is 1, `rdData` shows the next stored byte, and each cycle with `rdPop` high moves to the following byte. The bytes come out in arrival order.
- R4: Once as many bytes as `byteCount` have been popped, `rdData` reads 0 and further pops have no effect. Whenever `dataAvail` is 0, `rdData` is also 0.
- R5: A clean packet that arrives while `dataAvail` is 1 gets `hsNak` in the cycle after `pktEnd`. It leaves the byte count and the stored bytes unchanged.
- R6: A packet that ends with `pktCrcOk` low gets neither ACK nor NAK. It leaves the flag, the byte count and the expected toggle unchanged.
- R7: A packet with more than 64 bytes gets neither ACK nor NAK and leaves the flag, the count and the toggle unchanged.
- R8: A clean packet whose toggle differs from the expected one is a retransmission. It is ACKed, but it is not committed, and the flag stays 0.
- R9: `clrAvail` high while `dataAvail` is 1 drops `dataAvail` on the next cycle and arms the endpoint for the following packet.
- R10: The boundary lengths 0 and 64 are both accepted, with `byteCount` of 0 and 64 respectively.
- R11: `hsAck` and `hsNak` are single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pktStart | input | 1 | Start of an OUT data packet |
| pktToggle | input | 1 | Data PID toggle bit: 0 = DATA0, 1 = DATA1 (valid with `pktStart`) |
| pktByteValid | input | 1 | A payload byte is present on `pktByte` |
| pktByte | input | 8 | Payload byte |
| pktEnd | input | 1 | End of packet (never in the same cycle as a byte) |
| pktCrcOk | input | 1 | CRC good, valid with `pktEnd` |
| rdPop | input | 1 | Advance to the next stored byte |
| clrAvail | input | 1 | Write-1 clear of the data-available flag |
| hsAck | output | 1 | ACK handshake pulse |
| hsNak | output | 1 | NAK handshake pulse |
| dataAvail | output | 1 | Data-available interrupt flag |
| byteCount | output | 7 | Byte count of the committed packet |
| rdData | output | 8 | Byte at the read position, or 0 |

## Verification
The bench sweeps every payload length from 0 to 64, giving each length its own byte pattern computed from the length and the byte index, and alternates the toggle bit. This shows whether counting, ordering and toggle tracking hold at every fill level, including both edges. Packets sent into a full endpoint, with a bad CRC, with 65 bytes or with a repeated toggle are mixed into the sweep. A following packet with the toggle the bench expects tells apart a discard that left the state alone from one that disturbed the count, the data or the toggle.

// File: rtl/oep_pkg.sv
package oep_pkg;
  typedef struct packed {
    logic byteIn;
    logic wrEn;
    logic pktClr;
    logic commit;
    logic popEn;
    logic showRd;
  } dpCtl_t;
endpackage

// File: rtl/oep_datapath.sv
module oep_datapath
  import oep_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int DATA_W = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  dpCtl_t                     ctl,
  input  logic [DATA_W-1:0]          inByte,
  output logic                       wrFull,
  output logic                       hasData,
  output logic [$clog2(DEPTH):0]     byteCount,
  output logic [DATA_W-1:0]          rdByte
);
  localparam int ADDR_W = $clog2(DEPTH);
  localparam int CNT_W  = ADDR_W + 1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [CNT_W-1:0]  wrIdx;
  logic [CNT_W-1:0]  rdPtr;
  logic [CNT_W-1:0]  cntQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrIdx <= '0;
      rdPtr <= '0;
      cntQ  <= '0;
    end else begin
      if (ctl.pktClr)      wrIdx <= '0;
      else if (ctl.byteIn) wrIdx <= wrIdx + 1'b1;
      if (ctl.commit) begin
        cntQ  <= wrIdx;
        rdPtr <= '0;
      end else if (ctl.popEn) begin
        rdPtr <= rdPtr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (ctl.wrEn) mem[wrIdx[ADDR_W-1:0]] <= inByte;
  end

  assign wrFull    = (wrIdx == CNT_W'(DEPTH));
  assign hasData   = (rdPtr < cntQ);
  assign byteCount = cntQ;
  assign rdByte    = (ctl.showRd && hasData) ? mem[rdPtr[ADDR_W-1:0]] : '0;
endmodule

// File: rtl/oep_control.sv
module oep_control
  import oep_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   pktStart,
  input  logic   pktToggle,
  input  logic   pktByteValid,
  input  logic   pktEnd,
  input  logic   pktCrcOk,
  input  logic   rdPop,
  input  logic   clrAvail,
  input  logic   wrFull,
  input  logic   hasData,
  output dpCtl_t ctl,
  output logic   dataAvail,
  output logic   hsAck,
  output logic   hsNak
);
  logic rxActive, ovfQ, pidQ, expTog, availQ, ackQ, nakQ;
  logic byteTake, goodEnd, accept, fresh;

  always_comb begin
    byteTake   = pktByteValid && rxActive && !wrFull;
    goodEnd    = pktEnd && rxActive && pktCrcOk && !ovfQ;
    accept     = goodEnd && !availQ;
    fresh      = accept && (pidQ == expTog);
    ctl.byteIn = byteTake;
    ctl.wrEn   = byteTake && !availQ;
    ctl.pktClr = pktStart;
    ctl.commit = fresh;
    ctl.popEn  = rdPop && availQ && hasData;
    ctl.showRd = availQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxActive <= 1'b0;
      ovfQ     <= 1'b0;
      pidQ     <= 1'b0;
      expTog   <= 1'b0;
      availQ   <= 1'b0;
      ackQ     <= 1'b0;
      nakQ     <= 1'b0;
    end else begin
      ackQ <= accept;
      nakQ <= goodEnd && availQ;
      if (pktEnd) rxActive <= 1'b0;
      if (pktByteValid && rxActive && wrFull) ovfQ <= 1'b1;
      if (pktStart) begin
        rxActive <= 1'b1;
        ovfQ     <= 1'b0;
        pidQ     <= pktToggle;
      end
      if (fresh) begin
        availQ <= 1'b1;
        expTog <= ~expTog;
      end else if (clrAvail && availQ) begin
        availQ <= 1'b0;
      end
    end
  end

  assign dataAvail = availQ;
  assign hsAck     = ackQ;
  assign hsNak     = nakQ;
endmodule

// File: rtl/out_ep_rx_buffer.sv
module out_ep_rx_buffer
  import oep_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pktStart,
  input  logic              pktToggle,
  input  logic              pktByteValid,
  input  logic [DATA_W-1:0] pktByte,
  input  logic              pktEnd,
  input  logic              pktCrcOk,
  input  logic              rdPop,
  input  logic              clrAvail,
  output logic              hsAck,
  output logic              hsNak,
  output logic              dataAvail,
  output logic [CNT_W-1:0]  byteCount,
  output logic [DATA_W-1:0] rdData
);
  dpCtl_t ctl;
  logic   wrFull, hasData;

  oep_control uCtrl (
    .clk, .rstN, .pktStart, .pktToggle, .pktByteValid, .pktEnd, .pktCrcOk,
    .rdPop, .clrAvail, .wrFull, .hasData, .ctl, .dataAvail, .hsAck, .hsNak
  );

  oep_datapath #(.DEPTH(DEPTH), .DATA_W(DATA_W)) uData (
    .clk, .rstN, .ctl, .inByte(pktByte), .wrFull, .hasData,
    .byteCount, .rdByte(rdData)
  );
endmodule

// File: rtl/oep_checker.sv
module oep_checker #(
  parameter int DEPTH = 64,
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              hsAck,
  input logic              hsNak,
  input logic              dataAvail,
  input logic              clrAvail,
  input logic [CNT_W-1:0]  byteCount,
  input logic [DATA_W-1:0] rdData
);
  // R11
  hs_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(hsAck && hsNak));
  // R11
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    hsAck |=> !hsAck);
  // R2
  avail_rise_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dataAvail) |-> hsAck);
  // R5
  nak_when_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    hsNak |-> $past(dataAvail));
  // R5
  count_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$rose(dataAvail) |-> $stable(byteCount));
  // R9
  clear_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dataAvail && clrAvail) |=> !dataAvail);
  // R4
  idle_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !dataAvail |-> (rdData == '0));
  // R10
  count_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    byteCount <= CNT_W'(DEPTH));
endmodule

bind out_ep_rx_buffer oep_checker #(.DEPTH(DEPTH), .DATA_W(DATA_W)) uChk (
  .clk(clk), .rstN(rstN), .hsAck(hsAck), .hsNak(hsNak), .dataAvail(dataAvail),
  .clrAvail(clrAvail), .byteCount(byteCount), .rdData(rdData)
);

// File: tb/out_ep_rx_buffer_test.sv
module out_ep_rx_buffer_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       pktStart = 0, pktToggle = 0, pktByteValid = 0, pktEnd = 0, pktCrcOk = 0;
  logic [7:0] pktByte = '0;
  logic       rdPop = 0, clrAvail = 0;
  logic       hsAck, hsNak, dataAvail;
  logic [6:0] byteCount;
  logic [7:0] rdData;
  int         nChecks = 0, nFails = 0;
  bit         expTog = 1'b0;
  int         lastCnt = 0;

  always #4 clk = ~clk;

  out_ep_rx_buffer uut (
    .clk, .rstN, .pktStart, .pktToggle, .pktByteValid, .pktByte, .pktEnd,
    .pktCrcOk, .rdPop, .clrAvail, .hsAck, .hsNak, .dataAvail, .byteCount, .rdData
  );

  function automatic logic [7:0] pat(int len, int i);
    return 8'((len * 13 + i * 5 + 1) & 8'hFF);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Drives one packet; returns handshakes seen in the cycle after pktEnd
  // and in the cycle after that.
  task automatic sendPkt(input bit tog, input int len, input bit crc,
                         output bit ack, output bit nak, output bit ack2, output bit nak2);
    @(negedge clk);
    pktStart = 1; pktToggle = tog;
    @(negedge clk);
    pktStart = 0;
    for (int i = 0; i < len; i++) begin
      pktByteValid = 1; pktByte = pat(len, i);
      @(negedge clk);
    end
    pktByteValid = 0;
    pktEnd = 1; pktCrcOk = crc;
    @(negedge clk);
    pktEnd = 0; pktCrcOk = 0;
    ack = hsAck; nak = hsNak;
    @(negedge clk);
    ack2 = hsAck; nak2 = hsNak;
  endtask

  task automatic drainCheck(input int len);
    for (int i = 0; i < len; i++) begin
      check(rdData == pat(len, i), "R3 byte order", rdData, pat(len, i));
      rdPop = 1;
      @(negedge clk);
      rdPop = 0;
    end
    for (int k = 0; k < 2; k++) begin
      check(rdData == 8'h00, "R4 read past count", rdData, 0);
      rdPop = 1;
      @(negedge clk);
      rdPop = 0;
    end
  endtask

  task automatic clearFlag();
    clrAvail = 1;
    @(negedge clk);
    clrAvail = 0;
    check(dataAvail == 1'b0, "R9 clear flag", dataAvail, 0);
    check(rdData == 8'h00, "R4 read zero when clear", rdData, 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    bit a, n, a2, n2;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check(dataAvail == 0, "R1 reset flag", dataAvail, 0);
    check(byteCount == 0, "R1 reset count", byteCount, 0);
    check(rdData == 0, "R1 reset read data", rdData, 0);

    // Toggle DATA1 first: R1 expects DATA0, so it is a retransmission (R8)
    sendPkt(1'b1, 5, 1'b1, a, n, a2, n2);
    check(a == 1 && n == 0, "R8 retransmission acked", {a, n}, 2);
    check(dataAvail == 0, "R8 retransmission not committed", dataAvail, 0);
    check(byteCount == 0, "R1 toggle DATA0 count untouched", byteCount, 0);

    for (int len = 0; len <= 64; len++) begin
      sendPkt(expTog, len, 1'b1, a, n, a2, n2);
      check(a == 1 && n == 0, "R2 ack", {a, n}, 2);
      check(a2 == 0 && n2 == 0, "R11 single-cycle handshake", {a2, n2}, 0);
      check(dataAvail == 1, "R2 flag set", dataAvail, 1);
      check(byteCount == len, (len == 0 || len == 64) ? "R10 edge count" : "R2 count",
            byteCount, len);
      expTog = ~expTog;
      lastCnt = len;
      if (len % 8 == 0) begin
        sendPkt(expTog, 3, 1'b1, a, n, a2, n2);
        check(a == 0 && n == 1, "R5 nak while full", {a, n}, 1);
        check(byteCount == len, "R5 count kept", byteCount, len);
      end
      drainCheck(len);
      check(dataAvail == 1, "R4 flag held after reads", dataAvail, 1);
      clearFlag();
      if (len % 16 == 5) begin
        sendPkt(~expTog, 4, 1'b1, a, n, a2, n2);
        check(a == 1 && n == 0, "R8 repeat toggle acked", {a, n}, 2);
        check(dataAvail == 0, "R8 repeat toggle no flag", dataAvail, 0);
      end
    end

    sendPkt(expTog, 10, 1'b0, a, n, a2, n2);
    check(a == 0 && n == 0, "R6 bad crc silent", {a, n}, 0);
    check(dataAvail == 0, "R6 flag unchanged", dataAvail, 0);
    check(byteCount == lastCnt, "R6 count unchanged", byteCount, lastCnt);

    sendPkt(expTog, 65, 1'b1, a, n, a2, n2);
    check(a == 0 && n == 0, "R7 overflow silent", {a, n}, 0);
    check(dataAvail == 0, "R7 flag unchanged", dataAvail, 0);
    check(byteCount == lastCnt, "R7 count unchanged", byteCount, lastCnt);

    // The toggle must have survived both discards (R6, R7)
    sendPkt(expTog, 4, 1'b1, a, n, a2, n2);
    check(a == 1 && dataAvail == 1, "R7 toggle kept after discard", {a, dataAvail}, 3);
    check(byteCount == 4, "R9 rearmed accept", byteCount, 4);
    drainCheck(4);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule